// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a small processor whose datapath reuses a single ALU and a single memory across several clock cycles. Every instruction starts with the same two steps. The first step fetches the instruction and advances the program counter. The second step decodes the instruction and reads the register operands. While decoding, it also computes a branch target, whether or not the instruction is a branch. From that point each instruction class takes its own path through the remaining steps, and every path ends by returning to fetch.

The controller is a Moore machine: each control output is a function of the current state only. The 6-bit opcode, taken from the instruction register, only chooses which state comes next. The datapath around the controller is built elsewhere. This includes the program counter, the instruction and data registers, the register file, the ALU, the memory, and the ALU function decoder that consumes the 2-bit operation class.

States and their codes:

| Code | State | Next state |
|------|-------|------------|
| 0 | FETCH | DECODE |
| 1 | DECODE | chosen by opcode |
| 2 | ADDR | LDMEM or STMEM |
| 3 | LDMEM | LDWB |
| 4 | LDWB | FETCH |
| 5 | STMEM | FETCH |
| 6 | EXEC | ALUWB |
| 7 | ALUWB | FETCH |
| 8 | BRANCH | FETCH |
| 9 | JUMP | FETCH |

From DECODE the controller moves as follows:

| Opcode | Instruction class | Next state |
|--------|-------------------|------------|
| 35 | load | ADDR |
| 43 | store | ADDR |
| 0 | register arithmetic | EXEC |
| 4 | branch-if-equal | BRANCH |
| 2 | jump | JUMP |
| any other | unknown | FETCH |

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes FETCH (`step_code` = 0) with the FETCH control values. This applies even in the middle of an instruction.
- R2: FETCH drives the following values and is always followed by DECODE.
  - `mem_rd`=1, `ir_wr`=1 and `pc_wr`=1.
  - `alu_a_sel`=0 (A input is the PC) and `alu_b_sel`=01 (B input is the constant 4).
  - `alu_op`=00 (add), `pc_sel`=00 (PC takes the ALU result) and `addr_sel`=0 (memory address is the PC).
  - Every other output is 0.
- R3: DECODE drives `alu_a_sel`=0, `alu_b_sel`=11 (B input is the shifted, sign-extended offset) and `alu_op`=00, with no write enable active. Its next state is chosen by opcode:
  - 35 or 43 go to ADDR (code 2).
  - 0 goes to EXEC (code 6).
  - 4 goes to BRANCH (code 8).
  - 2 goes to JUMP (code 9).
  - Any other opcode goes to FETCH.
- R4: ADDR (code 2) drives `alu_a_sel`=1, `alu_b_sel`=10 (B input is the sign-extended offset) and `alu_op`=00. Opcode 35 then goes to LDMEM (code 3), and opcode 43 goes to STMEM (code 5).
- R5: LDMEM drives `mem_rd`=1 and `addr_sel`=1. It is followed by LDWB (code 4), which drives `reg_wr`=1, `wb_from_mem`=1 and `dst_rd`=0. A load therefore takes 5 cycles.
- R6: STMEM drives `mem_wr`=1 and `addr_sel`=1, then returns to FETCH. A store takes 4 cycles.
- R7: EXEC drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10 (function field decides). It is followed by ALUWB (code 7), which drives `reg_wr`=1, `dst_rd`=1 and `wb_from_mem`=0. A register-arithmetic instruction takes 4 cycles.
- R8: BRANCH drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract for compare), `pc_wr_cond`=1 and `pc_sel`=01 (PC takes the target computed in DECODE). A branch takes 3 cycles.
- R9: JUMP drives `pc_wr`=1 and `pc_sel`=10 (PC takes its own upper bits joined to the shifted 26-bit target). A jump takes 3 cycles.
- R10: An opcode outside {0, 2, 4, 35, 43} completes in 2 cycles (FETCH, DECODE). No memory write, register write or conditional PC write is raised at any point.
- R11: Control outputs depend only on the state. Changing `opcode` within a cycle leaves every control output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC load |
| pc_wr_cond | output | 1 | PC load when the ALU reports equal operands |
| reg_wr | output | 1 | Register file write enable |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU output register |
| wb_from_mem | output | 1 | Register write data: 0 = ALU output register, 1 = memory data register |
| dst_rd | output | 1 | Destination register: 0 = bits 20..16, 1 = bits 15..11 |
| alu_a_sel | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B input: 00 = register B, 01 = 4, 10 = offset, 11 = offset shifted by 2 |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| pc_sel | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| step_code | output | 4 | Current state code |

## Verification
The hardest behaviour to reach from the ports is the treatment of unused opcodes, together with the requirement that outputs never react to the opcode. Both are invisible unless every opcode is actually presented in DECODE and the outputs are watched while the opcode moves. The bench sweeps all 64 opcode values, each from a fresh FETCH, and follows the full state walk, checking the cycle count against the class-specific length. In every state it flips all opcode bits partway through the cycle and confirms the control vector holds still. A reset asserted partway through a load checks the synchronous return to FETCH.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPW = 6;
    localparam int STW = 4;

    typedef enum logic [STW-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDMEM  = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STMEM  = 4'd5,
        ST_EXEC   = 4'd6,
        ST_ALUWB  = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9
    } state_e;

    localparam logic [OPW-1:0] OP_RTYPE = 6'd0;
    localparam logic [OPW-1:0] OP_JMP   = 6'd2;
    localparam logic [OPW-1:0] OP_BEQ   = 6'd4;
    localparam logic [OPW-1:0] OP_LOAD  = 6'd35;
    localparam logic [OPW-1:0] OP_STORE = 6'd43;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       reg_wr;
        logic       addr_sel;
        logic       wb_from_mem;
        logic       dst_rd;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic [1:0] pc_sel;
    } ctl_t;

endpackage

// File: rtl/mcc_next.sv
module mcc_next
    import mcc_pkg::*;
(
    input  state_e         cur,
    input  logic [OPW-1:0] opcode,
    output state_e         nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_LOAD || opcode == OP_STORE) nxt = ST_ADDR;
                else if (opcode == OP_RTYPE)                 nxt = ST_EXEC;
                else if (opcode == OP_BEQ)                   nxt = ST_BRANCH;
                else if (opcode == OP_JMP)                   nxt = ST_JUMP;
                else                                         nxt = ST_FETCH;
            end
            ST_ADDR: begin
                if (opcode == OP_LOAD)       nxt = ST_LDMEM;
                else if (opcode == OP_STORE) nxt = ST_STMEM;
                else                         nxt = ST_FETCH;
            end
            ST_LDMEM:  nxt = ST_LDWB;
            ST_EXEC:   nxt = ST_ALUWB;
            ST_LDWB, ST_STMEM, ST_ALUWB, ST_BRANCH, ST_JUMP: nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
    import mcc_pkg::*;
(
    input  state_e cur,
    output ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = 2'b01;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = 2'b11;
            end
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_LDMEM: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.reg_wr      = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_STMEM: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_op    = 2'b10;
            end
            ST_ALUWB: begin
                ctl.reg_wr = 1'b1;
                ctl.dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_op     = 2'b01;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_sel     = 2'b01;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_sel = 2'b10;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           ir_wr,
    output logic           pc_wr,
    output logic           pc_wr_cond,
    output logic           reg_wr,
    output logic           addr_sel,
    output logic           wb_from_mem,
    output logic           dst_rd,
    output logic           alu_a_sel,
    output logic [1:0]     alu_b_sel,
    output logic [1:0]     alu_op,
    output logic [1:0]     pc_sel,
    output logic [STW-1:0] step_code
);

    state_e state_q;
    state_e state_d;
    ctl_t   ctl;

    mcc_next u_next (
        .cur    (state_q),
        .opcode (opcode),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    mcc_decode u_dec (
        .cur (state_q),
        .ctl (ctl)
    );

    assign mem_rd      = ctl.mem_rd;
    assign mem_wr      = ctl.mem_wr;
    assign ir_wr       = ctl.ir_wr;
    assign pc_wr       = ctl.pc_wr;
    assign pc_wr_cond  = ctl.pc_wr_cond;
    assign reg_wr      = ctl.reg_wr;
    assign addr_sel    = ctl.addr_sel;
    assign wb_from_mem = ctl.wb_from_mem;
    assign dst_rd      = ctl.dst_rd;
    assign alu_a_sel   = ctl.alu_a_sel;
    assign alu_b_sel   = ctl.alu_b_sel;
    assign alu_op      = ctl.alu_op;
    assign pc_sel      = ctl.pc_sel;
    assign step_code   = state_q;

    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R2

    AST_LOAD_WB_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LDWB) |-> ($past(state_q) == ST_LDMEM)); // R5

    AST_STORE_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($past(alu_b_sel) == 2'b10)); // R6

    AST_RTYPE_WB_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && dst_rd) |-> ($past(alu_op) == 2'b10)); // R7

    AST_BRANCH_FROM_DECODE: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |-> ($past(state_q) == ST_DECODE && $past(opcode) == OP_BEQ)); // R8

    AST_LAST_STEP_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {ST_LDWB, ST_STMEM, ST_ALUWB, ST_BRANCH, ST_JUMP})
        |=> (state_q == ST_FETCH)); // R9

endmodule

// File: tb/sim_mc_ctrl_fsm.sv
module sim_mc_ctrl_fsm;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr;
    logic addr_sel, wb_from_mem, dst_rd, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_sel;
    logic [3:0] step_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mc_ctrl_fsm u0 (
        .clk(clk), .rst(rst), .opcode(opcode),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .reg_wr(reg_wr), .addr_sel(addr_sel),
        .wb_from_mem(wb_from_mem), .dst_rd(dst_rd), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_sel(pc_sel),
        .step_code(step_code)
    );

    wire [15:0] ctl_v = {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr,
                         addr_sel, wb_from_mem, dst_rd, alu_a_sel,
                         alu_b_sel, alu_op, pc_sel};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bit order: rd wr ir pcw pcc regw addr wbm dst a b[1:0] op[1:0] pcs[1:0]
    function automatic logic [15:0] exp_ctl(input int s);
        case (s)
            0: return {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00};
            1: return {10'b0, 2'b11, 2'b00, 2'b00};
            2: return {9'b0, 1'b1, 2'b10, 2'b00, 2'b00};
            3: return {1'b1, 5'b0, 1'b1, 3'b0, 6'b0};
            4: return {5'b0, 1'b1, 1'b0, 1'b1, 2'b0, 6'b0};
            5: return {1'b0, 1'b1, 4'b0, 1'b1, 3'b0, 6'b0};
            6: return {9'b0, 1'b1, 2'b00, 2'b10, 2'b00};
            7: return {5'b0, 1'b1, 2'b0, 1'b1, 1'b0, 6'b0};
            8: return {4'b0, 1'b1, 4'b0, 1'b1, 2'b00, 2'b01, 2'b01};
            9: return {3'b0, 1'b1, 6'b0, 2'b00, 2'b00, 2'b10};
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic int exp_nxt(input int s, input int op);
        case (s)
            0: return 1;
            1: begin
                if (op == 35 || op == 43) return 2;
                if (op == 0) return 6;
                if (op == 4) return 8;
                if (op == 2) return 9;
                return 0;
            end
            2: return (op == 35) ? 3 : 5;
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of_state(input int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int exp_len(input int op);
        if (op == 35) return 5;
        if (op == 43 || op == 0) return 4;
        if (op == 4 || op == 2) return 3;
        return 2;
    endfunction

    function automatic string req_of_len(input int op);
        if (op == 35) return "R5";
        if (op == 43) return "R6";
        if (op == 0) return "R7";
        if (op == 4) return "R8";
        if (op == 2) return "R9";
        return "R10";
    endfunction

    initial begin
        rst = 1'b1;
        opcode = 6'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", step_code, 0);
        chk("R1 reset controls", ctl_v, exp_ctl(0));

        for (int op = 0; op < 64; op++) begin
            int st;
            int cyc;
            bit writes_seen;
            opcode = op[5:0];
            st = 0;
            cyc = 0;
            writes_seen = 1'b0;
            for (int k = 0; k < 8; k++) begin
                int nx;
                chk(req_of_state(st), step_code, st);
                chk(req_of_state(st), ctl_v, exp_ctl(st));
                if (st != 0 && (mem_wr || reg_wr || pc_wr_cond)) writes_seen = 1'b1;
                opcode = ~op[5:0];
                #0.5;
                chk("R11 opcode flip", ctl_v, exp_ctl(st));
                opcode = op[5:0];
                nx = exp_nxt(st, op);
                @(posedge clk);
                @(negedge clk);
                cyc++;
                st = nx;
                if (st == 0) break;
            end
            chk(req_of_len(op), cyc, exp_len(op));
            if (exp_len(op) == 2) chk("R10 no writes", writes_seen, 0);
        end

        // reset partway through a load
        opcode = 6'd35;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk("R5 reached load memory step", step_code, 3);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-instruction reset", step_code, 0);
        chk("R1 mid-instruction reset controls", ctl_v, exp_ctl(0));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule